// File: doc/BRIEF.md
# Program Fetch Address Mapper

This block sits between a processor's program counter and two sources of opcode bytes: on-chip code storage and an external program bus. Each cycle in which the fetch strobe is high, the block takes the 16-bit fetch address and routes it to one of the two sources. It then returns the opcode byte with a data-valid flag.

The choice between the sources is made once per reset. A select pin is sampled while reset is held and is then frozen. A low pin selects external fetching for every address. A high pin selects on-chip fetching. In on-chip mode, on-chip code covers addresses 0000h to F7FFh. Any fetch above F7FFh returns a fixed no-operation byte and never goes out onto the external bus.

The on-chip store is modelled as a registered read of a computed byte pattern. External fetches drive the address and a one-cycle program strobe. The returned byte is taken from the bus one cycle after the strobe.

Top module: `pfm_fetch_mapper`

## Requirements
- R1: While reset is held and right after reset is released, `opcode_vld_o` and `ext_strobe_o` are low and `ext_addr_o` is 0000h.
- R2: The mode is taken from `ext_sel_n` while reset is held. A low level selects external mode and a high level selects on-chip mode.
- R3: After reset is released, a change on `ext_sel_n` does not change where fetches go until the next reset.
- R4: In on-chip mode, a fetch at an address up to F7FFh returns `A[7:0] ^ A[15:8] ^ 5Ah` on `opcode_o` one cycle after the fetch, with `opcode_vld_o` high in that cycle.
- R5: In on-chip mode, a fetch at an address from F800h to FFFFh returns 00h one cycle after the fetch, with `opcode_vld_o` high.
- R6: In on-chip mode, `ext_strobe_o` never goes high for any address, including addresses above F7FFh.
- R7: In external mode, the cycle after a fetch shows the fetch address on `ext_addr_o` with `ext_strobe_o` high. The strobe lasts exactly one cycle per single fetch.
- R8: In external mode, the byte on `ext_data_i` during the strobe cycle is presented on `opcode_o` in the next cycle, with `opcode_vld_o` high.
- R9: In external mode, addresses from F800h to FFFFh go to the external bus like any other address and never return the no-operation byte.
- R10: `opcode_vld_o` is high only in a cycle that answers an earlier fetch. Each fetch produces exactly one valid byte.
- R11: Back-to-back on-chip fetches on consecutive cycles return one byte per cycle, in fetch order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel_n | input | 1 | Mode select sampled during reset, low selects external fetching |
| fetch_req | input | 1 | Fetch strobe from the program counter |
| fetch_addr | input | 16 | Fetch address |
| ext_data_i | input | 8 | Byte read back from the external program bus |
| ext_addr_o | output | 16 | Address driven on the external program bus |
| ext_strobe_o | output | 1 | One-cycle program read strobe on the external bus |
| opcode_o | output | 8 | Returned opcode byte |
| opcode_vld_o | output | 1 | High in the cycle opcode_o carries a fetched byte |

## Verification
A wrong latched mode shows up at the first fetch after reset. In on-chip mode it would raise `ext_strobe_o` one cycle after the fetch. In external mode it would leave the strobe low and return a pattern byte. A wrong limit compare shows only at the boundary pair F7FFh/F800h, so both sides are fetched in each mode. An error in the valid pipeline appears as a byte with no matching expected entry, or as a missing byte, one or two cycles after the fetch.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic {
    MODE_ONCHIP   = 1'b0,
    MODE_EXTERNAL = 1'b1
  } fetch_mode_e;

  localparam int unsigned PFM_ADDR_W = 16;
  localparam int unsigned PFM_DATA_W = 8;
endpackage

// File: rtl/pfm_mode_latch.sv
module pfm_mode_latch
  import pfm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_sel_n,
  output logic        rst_int_n,
  output fetch_mode_e mode_o
);
  logic sync1_q, sync2_q;
  fetch_mode_e mode_q, mode_d;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  assign rst_int_n = sync2_q;

  // load the pin only while the internal reset is held
  always_comb begin
    mode_d = mode_q;
    if (!sync2_q) mode_d = ext_sel_n ? MODE_ONCHIP : MODE_EXTERNAL;
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pfm_int_rom.sv
module pfm_int_rom #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] SALT = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned SLICES = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int unsigned PAD_W  = SLICES * DATA_W;

  logic [PAD_W-1:0]  addr_pad;
  logic [DATA_W-1:0] fold [SLICES+1];
  logic [DATA_W-1:0] data_q, data_d;

  assign addr_pad = PAD_W'(rd_addr);
  assign fold[0]  = SALT;

  // computed content: salt xor every address slice
  for (genvar s = 0; s < SLICES; s++) begin : g_fold
    assign fold[s+1] = fold[s] ^ addr_pad[s*DATA_W +: DATA_W];
  end

  always_comb begin
    data_d = data_q;
    if (rd_en) data_d = fold[SLICES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign rd_data = data_q;
endmodule

// File: rtl/pfm_ext_port.sv
module pfm_ext_port #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_strobe_o,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              cap_vld_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              strobe_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (req)      addr_d = req_addr;
    if (strobe_q) data_d = bus_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      strobe_q <= 1'b0;
      data_q   <= '0;
      vld_q    <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      strobe_q <= req;
      data_q   <= data_d;
      vld_q    <= strobe_q;
    end
  end

  assign bus_addr_o   = addr_q;
  assign bus_strobe_o = strobe_q;
  assign cap_data_o   = data_q;
  assign cap_vld_o    = vld_q;
endmodule

// File: rtl/pfm_fetch_mapper.sv
module pfm_fetch_mapper
  import pfm_pkg::*;
#(
  parameter int unsigned ADDR_W = PFM_ADDR_W,
  parameter int unsigned DATA_W = PFM_DATA_W,
  parameter logic [ADDR_W-1:0] ONCHIP_TOP = 16'hF7FF,
  parameter logic [DATA_W-1:0] NOP_CODE   = 8'h00,
  parameter logic [DATA_W-1:0] ROM_SALT   = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sel_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              ext_strobe_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              opcode_vld_o
);
  logic        rst_int_n;
  fetch_mode_e mode;
  logic        in_range;
  logic        req_rom, req_nop, req_ext;
  logic        rom_vld_q, nop_vld_q;
  logic [DATA_W-1:0] rom_data, ext_data;
  logic        ext_vld;

  pfm_mode_latch u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_sel_n (ext_sel_n),
    .rst_int_n (rst_int_n),
    .mode_o    (mode)
  );

  assign in_range = (fetch_addr <= ONCHIP_TOP);
  assign req_ext  = rst_int_n && fetch_req && (mode == MODE_EXTERNAL);
  assign req_rom  = rst_int_n && fetch_req && (mode == MODE_ONCHIP) && in_range;
  assign req_nop  = rst_int_n && fetch_req && (mode == MODE_ONCHIP) && !in_range;

  pfm_int_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SALT(ROM_SALT)) u_rom (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_en   (req_rom),
    .rd_addr (fetch_addr),
    .rd_data (rom_data)
  );

  pfm_ext_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ext (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req          (req_ext),
    .req_addr     (fetch_addr),
    .bus_data_i   (ext_data_i),
    .bus_addr_o   (ext_addr_o),
    .bus_strobe_o (ext_strobe_o),
    .cap_data_o   (ext_data),
    .cap_vld_o    (ext_vld)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rom_vld_q <= 1'b0;
      nop_vld_q <= 1'b0;
    end else begin
      rom_vld_q <= req_rom;
      nop_vld_q <= req_nop;
    end
  end

  always_comb begin
    opcode_o = NOP_CODE;
    if (rom_vld_q)    opcode_o = rom_data;
    else if (ext_vld) opcode_o = ext_data;
  end

  assign opcode_vld_o = rom_vld_q | nop_vld_q | ext_vld;
endmodule

// File: rtl/pfm_fetch_mapper_chk.sv
module pfm_fetch_mapper_chk
  import pfm_pkg::*;
(
  input logic        clk,
  input logic        rst_int_n,
  input fetch_mode_e mode,
  input logic        fetch_req,
  input logic [15:0] fetch_addr,
  input logic [7:0]  ext_data_i,
  input logic [15:0] ext_addr_o,
  input logic        ext_strobe_o,
  input logic [7:0]  opcode_o,
  input logic        opcode_vld_o
);
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(rst_int_n) |-> $stable(mode)); // R3

  AST_NOP_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fetch_req && mode == MODE_ONCHIP && fetch_addr > 16'hF7FF)
      |=> (opcode_vld_o && opcode_o == 8'h00)); // R5

  AST_NO_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_ONCHIP) |-> !ext_strobe_o); // R6

  AST_EXT_STROBE_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fetch_req && mode == MODE_EXTERNAL)
      |=> (ext_strobe_o && ext_addr_o == $past(fetch_addr))); // R7

  AST_EXT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_strobe_o |=> (opcode_vld_o && opcode_o == $past(ext_data_i))); // R8

  AST_VLD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    opcode_vld_o |-> ($past(ext_strobe_o) || $past(fetch_req && mode == MODE_ONCHIP))); // R10
endmodule

bind pfm_fetch_mapper pfm_fetch_mapper_chk u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .mode         (mode),
  .fetch_req    (fetch_req),
  .fetch_addr   (fetch_addr),
  .ext_data_i   (ext_data_i),
  .ext_addr_o   (ext_addr_o),
  .ext_strobe_o (ext_strobe_o),
  .opcode_o     (opcode_o),
  .opcode_vld_o (opcode_vld_o)
);

// File: tb/pfm_fetch_mapper_tb.sv
module pfm_fetch_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_sel_n = 1'b1;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [7:0]  ext_data_i;
  logic [15:0] ext_addr_o;
  logic        ext_strobe_o;
  logic [7:0]  opcode_o;
  logic        opcode_vld_o;

  int n_cmp = 0;
  int n_bad = 0;
  int strobe_seen = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  // external memory model: byte depends on the bus address
  assign ext_data_i = ext_addr_o[7:0] + ext_addr_o[15:8] + 8'h03;

  pfm_fetch_mapper dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_sel_n    (ext_sel_n),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .ext_data_i   (ext_data_i),
    .ext_addr_o   (ext_addr_o),
    .ext_strobe_o (ext_strobe_o),
    .opcode_o     (opcode_o),
    .opcode_vld_o (opcode_vld_o)
  );

  function automatic logic [7:0] rom_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ext_val(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h03;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each returned byte
  always @(negedge clk) begin
    if (rst_n && opcode_vld_o) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected byte", {24'h0, opcode_o}, 32'hFFFF_FFFF);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'h0, opcode_o}, {24'h0, e});
      end
    end
    if (rst_n && ext_strobe_o) strobe_seen++;
  end

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n = 1'b0;
    ext_sel_n = pin;
    fetch_req = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 vld in reset", {31'h0, opcode_vld_o}, 0);
    check("R1 strobe in reset", {31'h0, ext_strobe_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 vld after reset", {31'h0, opcode_vld_o}, 0);
    check("R1 addr after reset", {16'h0, ext_addr_o}, 0);
  endtask

  // driver: on-chip fetch, one cycle
  task automatic fetch_int(input logic [15:0] a, input string tag);
    fetch_req = 1'b1;
    fetch_addr = a;
    exp_q.push_back(a > 16'hF7FF ? 8'h00 : rom_val(a));
    tag_q.push_back(tag);
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  // driver: external fetch, checks strobe and address then waits for data
  task automatic fetch_ext(input logic [15:0] a, input string tag);
    fetch_req = 1'b1;
    fetch_addr = a;
    exp_q.push_back(ext_val(a));
    tag_q.push_back(tag);
    @(negedge clk);
    fetch_req = 1'b0;
    check("R7 strobe high", {31'h0, ext_strobe_o}, 1);
    check("R7 bus addr", {16'h0, ext_addr_o}, {16'h0, a});
    @(negedge clk);
    check("R7 strobe single", {31'h0, ext_strobe_o}, 0);
    @(negedge clk);
  endtask

  initial begin
    // on-chip mode
    do_reset(1'b1);
    strobe_seen = 0;
    fetch_int(16'h0000, "R4 low");
    fetch_int(16'h1234, "R4 mid");
    fetch_int(16'hF7FF, "R4 top");
    fetch_int(16'hF800, "R5 first nop");
    fetch_int(16'hFFFF, "R5 last nop");
    for (int i = 0; i < 6; i++) fetch_int(16'hF7FC + 16'(i), "R11 burst across top");
    @(negedge clk);
    ext_sel_n = 1'b0;
    repeat (2) @(negedge clk);
    fetch_int(16'hABCD, "R3 pin low ignored");
    fetch_int(16'hFA00, "R3 nop kept");
    repeat (3) @(negedge clk);
    check("R6 no strobe in on-chip mode", strobe_seen, 0);
    check("R10 queue drained", exp_q.size(), 0);
    check("R2 on-chip mode picked", {16'h0, ext_addr_o}, 0);

    // external mode
    do_reset(1'b0);
    fetch_ext(16'h0010, "R8 low");
    fetch_ext(16'h7F3C, "R8 mid");
    fetch_ext(16'hF7FF, "R8 top");
    fetch_ext(16'hF800, "R9 above top");
    fetch_ext(16'hFFFF, "R9 last");
    ext_sel_n = 1'b1;
    repeat (2) @(negedge clk);
    fetch_ext(16'h2222, "R3 pin high ignored");
    fetch_ext(16'hFC01, "R2 external mode kept");
    repeat (3) @(negedge clk);
    check("R10 queue drained ext", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule